// File: doc/BRIEF.md
# Mixed-Precision Symmetric FIR Filter

This block is a direct-form finite impulse response filter for signed 8-bit sample streams. Each accepted sample enters a shift register that keeps the previous `ORDER` samples. Every tap multiplies its delayed sample by a coefficient stored in that tap, and a chain of adders sums all `ORDER+1` products at full precision. The filter produces one output sample for each input sample.

Each tap has its own multiplier precision. It can multiply the exact sample, or it can first clear the lowest 2, 4 or 6 bits of the sample. Cheap reduced-precision taps and exact taps can therefore sit side by side in the same filter. Coefficients are loaded as a half set plus the centre tap, and the bank mirrors them into a symmetric, linear-phase coefficient set. Configuration writes are accepted only while no sample is in flight, and an idle flag shows when that is the case.

Top module: `approx_fir`

## Requirements
- R1: For every accepted sample the output equals the sum over i = 0..ORDER of h_i * t_i(x[n-i]). Samples and coefficients are two's complement, t_i is the operand reduction configured for tap i, and the result is the exact full sum, with no rounding or saturation.
- R2: `out_vld_o` is high in exactly the cycle that follows the second rising edge after a cycle in which `in_vld_i` was high, and at no other time. There is one output per accepted sample.
- R3: The delay line advances only on a clock edge where `in_vld_i` is high. Idle cycles between samples do not change later results.
- R4: A coefficient write to address k, with 0 <= k <= ORDER/2, sets taps k and ORDER-k to the same value. For even ORDER the centre tap is written once. A write to an address above ORDER/2 changes no tap.
- R5: Truncation code 0 uses the sample unchanged. Codes 1, 2 and 3 clear the 2, 4 or 6 least-significant bits of the sample operand. The coefficient operand is never reduced.
- R6: A truncation write to address k, with 0 <= k <= ORDER, sets the code of tap k alone. Addresses above ORDER are ignored.
- R7: `idle_o` is high exactly when neither pipeline stage holds a sample. A coefficient or truncation write is ignored when `idle_o` is low or when `in_vld_i` is high in the same cycle.
- R8: After reset all coefficients are zero, all taps are exact, the delay line holds zeros, `out_vld_o` is low, `out_data_o` is zero and `idle_o` is high.
- R9: With every tap at -2^(COEF_W-1) and a stream of -2^(DATA_W-1) samples, the output reaches (ORDER+1)*2^(DATA_W+COEF_W-2) with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_vld_i | input | 1 | Sample strobe |
| in_data_i | input | DATA_W | Signed input sample |
| coef_we_i | input | 1 | Coefficient write strobe |
| coef_addr_i | input | AW | Half-set coefficient address (0..ORDER/2) |
| coef_data_i | input | COEF_W | Signed coefficient value |
| trunc_we_i | input | 1 | Truncation code write strobe |
| trunc_addr_i | input | AW | Tap index (0..ORDER) |
| trunc_mode_i | input | 2 | Truncation code: 0 exact, 1/2/3 clear 2/4/6 LSBs |
| out_vld_o | output | 1 | Output strobe, two cycles after the input strobe |
| out_data_o | output | DATA_W+COEF_W+clog2(ORDER+1) | Signed full-precision sum |
| idle_o | output | 1 | No sample in flight; configuration writes allowed |

## Verification
A corrupted delay-line entry or coefficient shows up as a wrong sum on the next output that uses it, which is two cycles after the sample that exposes it. An impulse traces each tap position individually within ORDER+3 cycles. A mis-mirrored coefficient or a wrong truncation code shows up only when the stimulus has a nonzero sample at that tap, and with low bits set in that sample. This is why the streams use random values with all bits active, and random per-tap codes. A write that is wrongly accepted while the filter is busy changes every later output, and this is detected by comparing against a model that kept the old coefficient.

// File: rtl/approx_fir_pkg.sv
package approx_fir_pkg;
  typedef enum logic [1:0] {
    TRUNC_NONE = 2'd0,
    TRUNC_2    = 2'd1,
    TRUNC_4    = 2'd2,
    TRUNC_6    = 2'd3
  } trunc_e;

  function automatic int unsigned acc_width(int unsigned dw, int unsigned cw, int unsigned ntap);
    return dw + cw + $clog2(ntap);
  endfunction
endpackage

// File: rtl/afir_tap_mul.sv
module afir_tap_mul
  import approx_fir_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned COEF_W = 12,
  localparam int unsigned PROD_W = DATA_W + COEF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [COEF_W-1:0] coef_i,
  input  trunc_e            mode_i,
  output logic [PROD_W-1:0] prod_o
);
  logic [DATA_W-1:0] keep_mask;
  logic [DATA_W-1:0] op_data;
  logic [PROD_W-1:0] prod_d;
  logic [PROD_W-1:0] prod_q;

  // data operand only; coefficient stays full width
  always_comb begin
    keep_mask = {DATA_W{1'b1}} << {mode_i, 1'b0};
    op_data   = data_i & keep_mask;
    prod_d    = PROD_W'($signed(op_data)) * PROD_W'($signed(coef_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   prod_q <= '0;
    else if (en_i) prod_q <= prod_d;
  end

  assign prod_o = prod_q;

  AST_TRUNC_LSB_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (prod_o & ~({PROD_W{1'b1}} << {$past(mode_i), 1'b0})) == '0) // R5
    else $error("truncated tap product has nonzero low bits");
endmodule

// File: rtl/afir_cfg_bank.sv
module afir_cfg_bank #(
  parameter int unsigned ORDER  = 24,
  parameter int unsigned COEF_W = 12,
  parameter int unsigned AW     = 5,
  localparam int unsigned NTAP  = ORDER + 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_ok_i,
  input  logic                        coef_we_i,
  input  logic [AW-1:0]               coef_addr_i,
  input  logic [COEF_W-1:0]           coef_data_i,
  input  logic                        trunc_we_i,
  input  logic [AW-1:0]               trunc_addr_i,
  input  logic [1:0]                  trunc_mode_i,
  output logic [NTAP-1:0][COEF_W-1:0] coef_o,
  output logic [NTAP-1:0][1:0]        mode_o
);
  logic [NTAP-1:0][COEF_W-1:0] coef_q;
  logic [NTAP-1:0][1:0]        mode_q;

  for (genvar i = 0; i < NTAP; i++) begin : g_tap
    // mirrored taps share one half-set address
    localparam int unsigned HalfIdx = (i <= ORDER / 2) ? i : ORDER - i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        coef_q[i] <= '0;
        mode_q[i] <= '0;
      end else if (wr_ok_i) begin
        if (coef_we_i && coef_addr_i == AW'(HalfIdx))
          coef_q[i] <= coef_data_i;
        if (trunc_we_i && trunc_addr_i == AW'(i))
          mode_q[i] <= trunc_mode_i;
      end
    end

    if (i <= ORDER / 2) begin : g_sym
      AST_COEF_SYMMETRIC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        coef_q[i] == coef_q[ORDER-i]) // R4
        else $error("coefficient pair %0d not symmetric", i);
    end
  end

  assign coef_o = coef_q;
  assign mode_o = mode_q;

  AST_CFG_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ok_i |=> $stable(coef_q) && $stable(mode_q)) // R7
    else $error("configuration changed while busy");
endmodule

// File: rtl/afir_delay_line.sv
module afir_delay_line #(
  parameter int unsigned ORDER  = 24,
  parameter int unsigned DATA_W = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       shift_i,
  input  logic [DATA_W-1:0]          data_i,
  output logic [ORDER:0][DATA_W-1:0] taps_o
);
  logic [ORDER-1:0][DATA_W-1:0] hist_q;

  for (genvar k = 0; k < ORDER; k++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      hist_q[k] <= '0;
      else if (shift_i) hist_q[k] <= (k == 0) ? data_i : hist_q[(k == 0) ? 0 : k-1];
    end
    assign taps_o[k+1] = hist_q[k];
  end

  assign taps_o[0] = data_i;

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(hist_q)) // R3
    else $error("delay line moved without a sample");

  AST_SHIFT_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> hist_q[0] == $past(data_i)) // R3
    else $error("delay line head not loaded");
endmodule

// File: rtl/afir_sum_chain.sv
module afir_sum_chain #(
  parameter int unsigned NTAP   = 25,
  parameter int unsigned PROD_W = 20,
  parameter int unsigned ACC_W  = 25
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        en_i,
  input  logic [NTAP-1:0][PROD_W-1:0] prod_i,
  output logic [ACC_W-1:0]            sum_o
);
  logic [NTAP-1:0][ACC_W-1:0] part;
  logic [ACC_W-1:0]           sum_q;

  assign part[0] = ACC_W'($signed(prod_i[0]));
  for (genvar k = 1; k < NTAP; k++) begin : g_add
    assign part[k] = part[k-1] + ACC_W'($signed(prod_i[k]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sum_q <= '0;
    else if (en_i) sum_q <= part[NTAP-1];
  end

  assign sum_o = sum_q;
endmodule

// File: rtl/approx_fir.sv
module approx_fir
  import approx_fir_pkg::*;
#(
  parameter int unsigned ORDER  = 24,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned COEF_W = 12,
  localparam int unsigned NTAP  = ORDER + 1,
  localparam int unsigned AW    = $clog2(NTAP),
  localparam int unsigned PROD_W = DATA_W + COEF_W,
  localparam int unsigned ACC_W = acc_width(DATA_W, COEF_W, NTAP)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_vld_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              coef_we_i,
  input  logic [AW-1:0]     coef_addr_i,
  input  logic [COEF_W-1:0] coef_data_i,
  input  logic              trunc_we_i,
  input  logic [AW-1:0]     trunc_addr_i,
  input  logic [1:0]        trunc_mode_i,
  output logic              out_vld_o,
  output logic [ACC_W-1:0]  out_data_o,
  output logic              idle_o
);
  logic                        vld_s1_q, vld_s2_q;
  logic                        wr_ok;
  logic [NTAP-1:0][COEF_W-1:0] coef;
  logic [NTAP-1:0][1:0]        mode;
  logic [NTAP-1:0][DATA_W-1:0] taps;
  logic [NTAP-1:0][PROD_W-1:0] prod;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_s1_q <= 1'b0;
      vld_s2_q <= 1'b0;
    end else begin
      vld_s1_q <= in_vld_i;
      vld_s2_q <= vld_s1_q;
    end
  end

  assign idle_o    = !vld_s1_q && !vld_s2_q;
  assign wr_ok     = idle_o && !in_vld_i;
  assign out_vld_o = vld_s2_q;

  afir_cfg_bank #(.ORDER(ORDER), .COEF_W(COEF_W), .AW(AW)) u_cfg (
    .clk_i, .rst_ni,
    .wr_ok_i     (wr_ok),
    .coef_we_i, .coef_addr_i, .coef_data_i,
    .trunc_we_i, .trunc_addr_i, .trunc_mode_i,
    .coef_o      (coef),
    .mode_o      (mode)
  );

  afir_delay_line #(.ORDER(ORDER), .DATA_W(DATA_W)) u_dly (
    .clk_i, .rst_ni,
    .shift_i (in_vld_i),
    .data_i  (in_data_i),
    .taps_o  (taps)
  );

  for (genvar i = 0; i < NTAP; i++) begin : g_mul
    afir_tap_mul #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_mul (
      .clk_i, .rst_ni,
      .en_i   (in_vld_i),
      .data_i (taps[i]),
      .coef_i (coef[i]),
      .mode_i (trunc_e'(mode[i])),
      .prod_o (prod[i])
    );
  end

  afir_sum_chain #(.NTAP(NTAP), .PROD_W(PROD_W), .ACC_W(ACC_W)) u_sum (
    .clk_i, .rst_ni,
    .en_i   (vld_s1_q),
    .prod_i (prod),
    .sum_o  (out_data_o)
  );

  AST_OUT_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_o == $past(in_vld_i, 2)) // R2
    else $error("output strobe latency wrong");

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |=> $stable(out_data_o)) // R7
    else $error("output changed while idle");
endmodule

// File: tb/approx_fir_tb.sv
`timescale 1ns/1ps
module approx_fir_tb;
  localparam int ORDER = 24, DATA_W = 8, COEF_W = 12;
  localparam int NTAP = ORDER + 1, HALF = ORDER / 2, AW = 5, ACC_W = 25;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic              in_vld = 0, coef_we = 0, trunc_we = 0;
  logic [DATA_W-1:0] in_data = '0;
  logic [AW-1:0]     coef_addr = '0, trunc_addr = '0;
  logic [COEF_W-1:0] coef_data = '0;
  logic [1:0]        trunc_mode = '0;
  logic              out_vld, idle;
  logic [ACC_W-1:0]  out_data;

  approx_fir #(.ORDER(ORDER), .DATA_W(DATA_W), .COEF_W(COEF_W)) u_dut (
    .clk_i(clk), .rst_ni, .in_vld_i(in_vld), .in_data_i(in_data),
    .coef_we_i(coef_we), .coef_addr_i(coef_addr), .coef_data_i(coef_data),
    .trunc_we_i(trunc_we), .trunc_addr_i(trunc_addr), .trunc_mode_i(trunc_mode),
    .out_vld_o(out_vld), .out_data_o(out_data), .idle_o(idle)
  );

  int n_chk = 0, n_bad = 0;
  int mh[NTAP], mm[NTAP], mx[NTAP];
  longint expq[$];
  logic [1:0] vh = 2'b00;
  string tag = "R8";

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint model_out();
    longint s = 0;
    for (int i = 0; i < NTAP; i++) begin
      int xt = (mx[i] >>> (2 * mm[i])) * (1 << (2 * mm[i]));
      s += longint'(xt) * longint'(mh[i]);
    end
    return s;
  endfunction

  function automatic void push_sample(int x);
    for (int i = NTAP - 1; i > 0; i--) mx[i] = mx[i-1];
    mx[0] = x;
    expq.push_back(model_out());
  endfunction

  always @(posedge clk) vh <= {vh[0], in_vld};

  always @(negedge clk) if (rst_ni) begin
    check("R2 strobe latency", longint'(out_vld), longint'(vh[1]));
    if (out_vld) begin
      if (expq.size() == 0) check({tag, " unexpected output"}, 1, 0);
      else check(tag, longint'($signed(out_data)), expq.pop_front());
    end
  end

  task automatic send(int x);
    @(negedge clk);
    in_vld = 1'b1; in_data = x[DATA_W-1:0];
    push_sample(x);
  endtask

  task automatic gap(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); in_vld = 1'b0; end
  endtask

  task automatic wcoef(int a, int v, bit upd);
    @(negedge clk);
    in_vld = 1'b0; coef_we = 1'b1; coef_addr = AW'(a); coef_data = v[COEF_W-1:0];
    if (upd && a <= HALF) begin mh[a] = v; mh[ORDER-a] = v; end
    @(negedge clk); coef_we = 1'b0;
  endtask

  task automatic wmode(int t, int m, bit upd);
    @(negedge clk);
    in_vld = 1'b0; trunc_we = 1'b1; trunc_addr = AW'(t); trunc_mode = m[1:0];
    if (upd && t < NTAP) mm[t] = m;
    @(negedge clk); trunc_we = 1'b0;
  endtask

  task automatic impulse(int amp);
    send(amp);
    for (int i = 0; i < ORDER; i++) send(0);
    gap(4);
  endtask

  function automatic int rnd_x();
    return int'($urandom_range(255)) - 128;
  endfunction

  initial begin
    for (int i = 0; i < NTAP; i++) begin mh[i] = 0; mm[i] = 0; mx[i] = 0; end
    repeat (4) @(negedge clk);
    // R8: reset state
    check("R8 idle", longint'(idle), 1);
    check("R8 valid", longint'(out_vld), 0);
    check("R8 data", longint'($signed(out_data)), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R8 idle after release", longint'(idle), 1);
    tag = "R8 zero coefs";
    impulse(100);

    // R4: load half set, impulse shows mirrored response
    tag = "R4 impulse";
    for (int k = 0; k <= HALF; k++) wcoef(k, ((k * 389) % 4001) - 2000, 1);
    impulse(1);
    impulse(-77);
    // R4: address above half is ignored
    tag = "R4 bad address";
    wcoef(HALF + 1, 1234, 0);
    wcoef(31, -5, 0);
    impulse(1);

    // R1: random stream, exact taps
    tag = "R1 random exact";
    for (int i = 0; i < 200; i++) send(rnd_x());
    gap(4);

    // R5/R6: random per-tap codes, R3 gaps
    tag = "R5 R6 mixed precision";
    for (int t = 0; t < NTAP; t++) wmode(t, int'($urandom_range(3)), 1);
    wmode(NTAP, 2, 0);
    wmode(31, 3, 0);
    for (int i = 0; i < 300; i++) begin
      send(rnd_x());
      if ($urandom_range(3) == 0) gap(int'($urandom_range(3)) + 1);
    end
    tag = "R3 gapped stream";
    for (int i = 0; i < 100; i++) begin send(rnd_x()); gap(int'($urandom_range(5))); end
    gap(4);

    // R5: one tap pair, tap 3 clears 4 bits, tap 21 exact
    tag = "R5 single tap";
    for (int k = 0; k <= HALF; k++) wcoef(k, 0, 1);
    for (int t = 0; t < NTAP; t++) wmode(t, 0, 1);
    wcoef(3, -1501, 1);
    wmode(3, 2, 1);
    wmode(21, 0, 1);
    impulse(127);
    wmode(3, 3, 1);
    wmode(21, 1, 1);
    impulse(-1);

    // R9: worst-case magnitude
    tag = "R9 extreme";
    for (int k = 0; k <= HALF; k++) wcoef(k, -2048, 1);
    for (int t = 0; t < NTAP; t++) wmode(t, 0, 1);
    for (int i = 0; i < 30; i++) send(-128);
    check("R9 model peak", expq[expq.size()-1], longint'(NTAP) * 262144);
    gap(4);

    // R7: writes ignored while busy or alongside a sample
    tag = "R7 locked config";
    send(5);
    @(negedge clk); in_vld = 1'b0;
    check("R7 idle low in flight", longint'(idle), 0);
    coef_we = 1'b1; coef_addr = 0; coef_data = 12'd777;
    trunc_we = 1'b1; trunc_addr = 0; trunc_mode = 2'd3;
    @(negedge clk); coef_we = 1'b0; trunc_we = 1'b0;
    gap(3);
    check("R7 idle high drained", longint'(idle), 1);
    @(negedge clk);
    in_vld = 1'b1; in_data = 8'd9; push_sample(9);
    coef_we = 1'b1; coef_addr = 1; coef_data = 12'd555;
    @(negedge clk); in_vld = 1'b0; coef_we = 1'b0;
    gap(4);
    impulse(3);
    for (int i = 0; i < 40; i++) send(rnd_x());
    gap(4);
    check("R2 all outputs seen", longint'(expq.size()), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule